// File: doc/BRIEF.md
# Row Spare-Column Repair Controller

This controller looks after one row of configurable logic elements. Some positions in the row are marked as spare columns by the configuration stream. A spare holds an all-zero (unconfigured) word until it is needed. The spares divide the row into segments: a segment runs from the element just after one spare marker up to and including the next marker.

When a live element raises its fault flag, the controller drops the operation enable. It then moves configuration words one place to the right, from the faulty element toward the spare that closes its segment. When the shift is done it sets the bypass select of the faulty element and raises the operation enable again. A set bypass select makes the element transparent for east-west traffic and moves its north-south connections one position to the right; the routing multiplexers that act on this select lie outside the block.

Each segment can absorb one fault. A fault that cannot be repaired raises a sticky kill signal, so that a higher level can replace the whole cell. All repair state is volatile. Reset clears it, and every new load clears it as well.

Top module: `rowrep_top`

## Requirements
- R1: After reset every word on `cfg_o` is zero, `bypass_o` is all zero, `run_o` is 1 and `kill_o` is 0.
- R2: A cycle with `load_i` high stores `cfg_i` word i (bits i*W+W-1..i*W) into position i, except that positions with `spare_i[i]`=1 store an all-zero word. The same cycle clears every bypass select, every used-spare mark and the kill state. Load takes priority over a repair in progress and aborts it, so `run_o` is 1 after it.
- R3: A fault at element f whose segment spare s is still unused makes `run_o` read 0 from the cycle after the fault is seen, for exactly s-f cycles.
- R4: The shift moves one word per cycle, starting at the spare end. The k-th shift cycle copies the word at position s-k into position s-k+1, so no word is overwritten before it has moved.
- R5: In the cycle the last copy (f into f+1) completes, `bypass_o[f]` becomes 1 and `run_o` returns to 1. The word at position f itself is left unchanged.
- R6: A fault flag from an element whose bypass is set, or from a spare that is still unused, has no effect on any output.
- R7: The segment of a fault at f is found by searching from f (inclusive) toward higher indices for the first spare-marked position. If none exists, or that spare is already used, `kill_o` reads 1 in the next cycle and no word moves.
- R8: Two live faults in the same cycle that map to the same spare raise `kill_o` in the next cycle, and no shift takes place.
- R9: Once `kill_o` is 1 it stays 1, `run_o` stays 0, and `cfg_o` and `bypass_o` stay frozen until a load or a reset.
- R10: Live faults in different segments in the same cycle are repaired one after another, lowest index first, with one cycle of `run_o`=1 between the repairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load configuration words and spare markers |
| cfg_i | input | N_ELEM*CFG_W | Configuration words, word i at bits i*CFG_W upward |
| spare_i | input | N_ELEM | Spare-column markers, 1 = spare position |
| fault_i | input | N_ELEM | Per-element fault flags, level |
| cfg_o | output | N_ELEM*CFG_W | Current (shifted) configuration words |
| bypass_o | output | N_ELEM | Per-element bypass select, 1 = element replaced |
| run_o | output | 1 | Operation enable for the row |
| kill_o | output | 1 | Row cannot be repaired; replace the cell |

## Verification
Two pairs of events can land in the same cycle. The first is two fault flags at once. Faults at elements 5 and 6, which share one spare, must give an immediate kill with no word moved. Faults at elements 0 and 5, which lie in separate segments, must give two full repairs in index order, each judged word by word against a reference shift model. The second is a load arriving in the middle of a shift: it is raised after the first shift cycle of a long repair, and the bench expects the freshly loaded words, cleared bypass selects and `run_o` high, with no trace of the abandoned shift.

// File: rtl/rowrep_pkg.sv
package rowrep_pkg;
  typedef enum logic [0:0] {ST_RUN = 1'b0, ST_SHIFT = 1'b1} rr_state_e;
endpackage

// File: rtl/rowrep_scan.sv
// Combinational fault qualification, segment search and kill decision.
module rowrep_scan #(
  parameter int N_ELEM = 8
) (
  input  logic [N_ELEM-1:0]         fault_i,
  input  logic [N_ELEM-1:0]         spare_q,
  input  logic [N_ELEM-1:0]         used_q,
  input  logic [N_ELEM-1:0]         byp_q,
  output logic [$clog2(N_ELEM)-1:0] pick_f,
  output logic [$clog2(N_ELEM)-1:0] pick_s,
  output logic                      pick_ok,
  output logic                      kill_req
);
  localparam int IDX_W = $clog2(N_ELEM);

  logic [N_ELEM-1:0] act;
  logic [N_ELEM-1:0] end_found;
  logic [IDX_W-1:0]  end_idx [N_ELEM];
  logic              any_act;

  always_comb begin
    act       = '0;
    end_found = '0;
    for (int f = 0; f < N_ELEM; f++) begin
      end_idx[f] = '0;
      // live element: not bypassed and not an idle spare
      act[f] = fault_i[f] & ~byp_q[f] & ~(spare_q[f] & ~used_q[f]);
      // nearest spare marker at or to the right of f
      for (int p = N_ELEM - 1; p >= 0; p--) begin
        if (p >= f && spare_q[p]) begin
          end_found[f] = 1'b1;
          end_idx[f]   = IDX_W'(p);
        end
      end
    end
  end

  always_comb begin
    kill_req = 1'b0;
    for (int f = 0; f < N_ELEM; f++) begin
      if (act[f] && (!end_found[f] || used_q[end_idx[f]])) kill_req = 1'b1;
      for (int g = f + 1; g < N_ELEM; g++) begin
        if (act[f] && act[g] && end_found[f] && end_found[g] &&
            end_idx[f] == end_idx[g]) kill_req = 1'b1;
      end
    end
  end

  always_comb begin
    any_act = 1'b0;
    pick_f  = '0;
    pick_s  = '0;
    for (int f = N_ELEM - 1; f >= 0; f--) begin
      if (act[f]) begin
        any_act = 1'b1;
        pick_f  = IDX_W'(f);
        pick_s  = end_idx[f];
      end
    end
    pick_ok = any_act & ~kill_req;
  end
endmodule

// File: rtl/rowrep_cfg.sv
// Configuration word store with a single-position right shift.
module rowrep_cfg #(
  parameter int N_ELEM = 8,
  parameter int CFG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_i,
  input  logic [N_ELEM*CFG_W-1:0]   cfg_i,
  input  logic [N_ELEM-1:0]         spare_i,
  input  logic                      shift_en,
  input  logic [$clog2(N_ELEM)-1:0] shift_ptr,
  output logic [N_ELEM*CFG_W-1:0]   word_o
);
  localparam int IDX_W = $clog2(N_ELEM);

  logic [N_ELEM*CFG_W-1:0] word_q;
  logic [N_ELEM*CFG_W-1:0] word_d;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_slot
    always_comb begin
      word_d[i*CFG_W +: CFG_W] = word_q[i*CFG_W +: CFG_W];
      if (load_i) begin
        word_d[i*CFG_W +: CFG_W] = spare_i[i] ? '0 : cfg_i[i*CFG_W +: CFG_W];
      end
      if (i > 0) begin : g_mv
        if (!load_i && shift_en && shift_ptr == IDX_W'(i))
          word_d[i*CFG_W +: CFG_W] = word_q[(i > 0 ? i - 1 : 0)*CFG_W +: CFG_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i*CFG_W +: CFG_W] <= '0;
      else        word_q[i*CFG_W +: CFG_W] <= word_d[i*CFG_W +: CFG_W];
    end
  end

  assign word_o = word_q;

  // R4
  shift_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> (shift_ptr != '0));
endmodule

// File: rtl/rowrep_top.sv
module rowrep_top
  import rowrep_pkg::*;
#(
  parameter int N_ELEM = 8,
  parameter int CFG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [N_ELEM*CFG_W-1:0] cfg_i,
  input  logic [N_ELEM-1:0]       spare_i,
  input  logic [N_ELEM-1:0]       fault_i,
  output logic [N_ELEM*CFG_W-1:0] cfg_o,
  output logic [N_ELEM-1:0]       bypass_o,
  output logic                    run_o,
  output logic                    kill_o
);
  localparam int IDX_W = $clog2(N_ELEM);

  rr_state_e         st_q, st_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d, f_q, f_d, s_q, s_d;
  logic [N_ELEM-1:0] spare_q, spare_d, used_q, used_d, bypass_q, bypass_d;
  logic              kill_q, kill_d;
  logic              shift_en;
  logic [IDX_W-1:0]  pick_f, pick_s;
  logic              pick_ok, kill_req;

  rowrep_scan #(.N_ELEM(N_ELEM)) u_scan (
    .fault_i (fault_i),
    .spare_q (spare_q),
    .used_q  (used_q),
    .byp_q   (bypass_q),
    .pick_f  (pick_f),
    .pick_s  (pick_s),
    .pick_ok (pick_ok),
    .kill_req(kill_req)
  );

  rowrep_cfg #(.N_ELEM(N_ELEM), .CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .cfg_i    (cfg_i),
    .spare_i  (spare_i),
    .shift_en (shift_en),
    .shift_ptr(ptr_q),
    .word_o   (cfg_o)
  );

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    f_d      = f_q;
    s_d      = s_q;
    spare_d  = spare_q;
    used_d   = used_q;
    bypass_d = bypass_q;
    kill_d   = kill_q;
    shift_en = 1'b0;
    if (load_i) begin
      spare_d  = spare_i;
      used_d   = '0;
      bypass_d = '0;
      kill_d   = 1'b0;
      st_d     = ST_RUN;
    end else if (!kill_q) begin
      unique case (st_q)
        ST_RUN: begin
          if (kill_req) begin
            kill_d = 1'b1;
          end else if (pick_ok) begin
            st_d  = ST_SHIFT;
            ptr_d = pick_s;
            f_d   = pick_f;
            s_d   = pick_s;
          end
        end
        ST_SHIFT: begin
          shift_en = 1'b1;
          ptr_d    = ptr_q - IDX_W'(1);
          if (ptr_q == f_q + IDX_W'(1)) begin
            bypass_d[f_q] = 1'b1;
            used_d[s_q]   = 1'b1;
            st_d          = ST_RUN;
          end
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      ptr_q    <= '0;
      f_q      <= '0;
      s_q      <= '0;
      spare_q  <= '0;
      used_q   <= '0;
      bypass_q <= '0;
      kill_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ptr_q    <= ptr_d;
      f_q      <= f_d;
      s_q      <= s_d;
      spare_q  <= spare_d;
      used_q   <= used_d;
      bypass_q <= bypass_d;
      kill_q   <= kill_d;
    end
  end

  assign bypass_o = bypass_q;
  assign kill_o   = kill_q;
  assign run_o    = (st_q == ST_RUN) && !kill_q;

  // R9
  kill_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_q && !load_i) |=> (kill_q && $stable(bypass_q)));

  // R5
  byp_quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && st_q == ST_RUN) |=> $stable(bypass_q));

  // R10
  byp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($countones(bypass_q & ~$past(bypass_q)) <= 1));
endmodule

// File: tb/tb_rowrep_top.sv
`timescale 1ns/100ps
module tb_rowrep_top;
  localparam int N = 8;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic load_i;
  logic [N*W-1:0] cfg_i;
  logic [N-1:0] spare_i, fault_i;
  logic [N*W-1:0] cfg_o;
  logic [N-1:0] bypass_o;
  logic run_o, kill_o;

  always #2 clk = ~clk;  // 250 MHz

  rowrep_top #(.N_ELEM(N), .CFG_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .cfg_i(cfg_i),
    .spare_i(spare_i), .fault_i(fault_i), .cfg_o(cfg_o),
    .bypass_o(bypass_o), .run_o(run_o), .kill_o(kill_o)
  );

  typedef struct {
    string          tag;
    logic [N*W-1:0] cfg;
    logic [N-1:0]   byp;
    logic           run;
    logic           kill;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_cfg [N];
  logic [N-1:0] m_byp;
  logic         m_run, m_kill;

  function automatic logic [N*W-1:0] flat_model();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = m_cfg[i];
    return v;
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.cfg = flat_model(); e.byp = m_byp;
    e.run = m_run; e.kill = m_kill;
    exp_q.push_back(e);
  endtask

  // monitor: compares just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (cfg_o !== e.cfg || bypass_o !== e.byp || run_o !== e.run || kill_o !== e.kill) begin
          n_bad++;
          $display("FAIL %s: cfg=%h byp=%b run=%b kill=%b expected cfg=%h byp=%b run=%b kill=%b",
                   e.tag, cfg_o, bypass_o, run_o, kill_o, e.cfg, e.byp, e.run, e.kill);
        end
      end
    end
  end

  task automatic do_load(input logic [N-1:0] sp, input string tag);
    @(negedge clk);
    load_i = 1'b1; spare_i = sp; fault_i = '0;
    @(negedge clk);
    load_i = 1'b0;
    for (int i = 0; i < N; i++) m_cfg[i] = sp[i] ? '0 : W'(8'h10 + i);
    m_byp = '0; m_run = 1'b1; m_kill = 1'b0;
    push(tag);
  endtask

  // fault already visible to the last rising edge
  task automatic shift_seq(input int f, input int s, input string tag);
    @(negedge clk);
    m_run = 1'b0;
    push({tag, " R3 run low"});
    for (int p = s; p > f; p--) begin
      @(negedge clk);
      m_cfg[p] = m_cfg[p-1];
      if (p == f + 1) begin
        m_byp[f] = 1'b1;
        m_run = 1'b1;
        push({tag, " R5 done"});
      end else begin
        push({tag, " R4 step"});
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; fault_i = '0; spare_i = '0;
    for (int i = 0; i < N; i++) cfg_i[i*W +: W] = W'(8'h10 + i);
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    m_byp = '0; m_run = 1'b1; m_kill = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R1 reset state");

    do_load(8'b1000_1000, "R2 load, spares zeroed");

    // R6: fault from an idle spare is ignored
    @(negedge clk); fault_i = 8'b0000_1000;
    @(negedge clk); push("R6 idle spare fault");
    fault_i = '0;
    @(negedge clk); push("R6 idle spare fault after");

    // R3 R4 R5: fault at 1, spare at 3
    @(negedge clk); fault_i[1] = 1'b1;
    shift_seq(1, 3, "seg0");
    // fault at 4, spare at 7; fault 1 still held but bypassed
    @(negedge clk); fault_i[4] = 1'b1;
    shift_seq(4, 7, "seg1");
    @(negedge clk); push("R6 bypassed faults held");

    // R7: new fault in segment whose spare is used
    @(negedge clk); fault_i = 8'b0000_0001;
    @(negedge clk); m_kill = 1'b1; m_run = 1'b0; push("R7 used spare kill");
    fault_i = 8'b0000_0100;
    repeat (2) @(negedge clk);
    push("R9 kill sticky");
    fault_i = '0;

    do_load(8'b1000_1000, "R2 reload clears kill");

    // R8: two faults sharing one spare
    @(negedge clk); fault_i = 8'b0110_0000;
    @(negedge clk); m_kill = 1'b1; m_run = 1'b0; push("R8 pair kill");
    @(negedge clk); push("R8 no shift");
    fault_i = '0;

    do_load(8'b1000_1000, "R2 reload");

    // R10: faults in two segments at once
    @(negedge clk); fault_i = 8'b0010_0001;
    shift_seq(0, 3, "R10 first");
    shift_seq(5, 7, "R10 second");
    fault_i = '0;

    // R7: no spare to the right
    do_load(8'b0000_1000, "R2 reload single spare");
    @(negedge clk); fault_i = 8'b0010_0000;
    @(negedge clk); m_kill = 1'b1; m_run = 1'b0; push("R7 no spare kill");
    fault_i = '0;

    // R2: load aborts a repair
    do_load(8'b1000_0000, "R2 reload far spare");
    @(negedge clk); fault_i = 8'b0000_0001;
    @(negedge clk); m_run = 1'b0; push("R3 long repair start");
    @(negedge clk); m_cfg[7] = m_cfg[6]; push("R4 first step");
    load_i = 1'b1; fault_i = '0; spare_i = 8'b1000_0000;
    @(negedge clk); load_i = 1'b0;
    for (int i = 0; i < N; i++) m_cfg[i] = (i == 7) ? '0 : W'(8'h10 + i);
    m_byp = '0; m_run = 1'b1; m_kill = 1'b0;
    push("R2 load aborts shift");
    @(negedge clk); push("R2 stays running");

    // R1: reset mid-operation clears everything
    @(negedge clk); fault_i = 8'b0000_0001;
    @(negedge clk); rst_n = 1'b0; fault_i = '0;
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    m_byp = '0; m_run = 1'b1; m_kill = 1'b0;
    @(negedge clk); push("R1 reset clears");
    rst_n = 1'b1;
    @(negedge clk); push("R1 after reset");

    @(negedge clk); #2;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule